// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It bases the guess on the branch address and on the recent outcomes of every branch that has executed, not only the one being predicted. One shared shift register records those outcomes. Its contents, joined with a few address bits of the branch, select one 2-bit saturating counter out of 16384. The counter's upper half means "taken".

The fetch side presents a PC and reads the direction in the same cycle, with no clock in the path. The resolve side presents the PC and real outcome of a finished branch. That trains the selected counter and pushes the outcome into the history. The counters sit in a RAM of packed words, so reset cannot clear them at once. Reset instead starts a sweep of 2048 cycles that writes every word. While the sweep runs, the block predicts not-taken and ignores training.

Top module: `ghp_predictor`

## Requirements
- R1: The counter index is 14 bits wide: the 8-bit history forms the upper part and PC bits [7:2] form the lower part. Branches whose PC bits [7:2] differ use separate counters.
- R2: A taken update raises the selected counter by one, and the counter stops at 3 without wrapping.
- R3: A not-taken update lowers the selected counter by one, and the counter stops at 0 without wrapping.
- R4: `pred_taken` is 1 exactly when the counter selected by `pred_pc` and the current history holds 2 or 3. It appears in the same cycle, with no register on the path.
- R5: Each accepted update shifts the history left by one place. The outcome enters at bit 0, with 1 meaning taken, and the oldest bit is dropped. No other event changes the history.
- R6: After reset the history is 0 and every counter holds 1 (weakly not-taken).
- R7: For 2048 clock cycles after reset is released, `pred_taken` is 0 and updates change neither counters nor history.
- R8: When a prediction and an update happen in the same cycle, the prediction reflects the counters and history as they were before that update.
- R9: PC bits outside [7:2] have no effect on which counter is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the counter sweep |
| pred_pc | input | 32 | Address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken (same cycle) |
| upd_valid | input | 1 | A resolved branch is presented for training |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome of the resolved branch, 1 = taken |

## Verification
The assertions take for granted that reset is high from the first clock edge, and that `upd_valid` and `upd_taken` are never unknown while reset is low. Under those conditions, the history register and the sweep flag always hold defined values. The bench drives every input on the falling edge, starting with reset held high. It keeps all inputs at defined values throughout, and it deliberately presents updates during the sweep so that the ignore rule is exercised.

// File: rtl/ghp_pkg.sv
package ghp_pkg;
  localparam int CTR_W = 2;
  typedef logic [CTR_W-1:0] ctr_t;
  localparam ctr_t CTR_RESET = 2'b01;
  localparam ctr_t CTR_MAX   = 2'b11;
  localparam ctr_t CTR_MIN   = 2'b00;

  function automatic ctr_t ctr_next(ctr_t c, logic taken);
    if (taken) return (c == CTR_MAX) ? c : c + 2'd1;
    else       return (c == CTR_MIN) ? c : c - 2'd1;
  endfunction

  function automatic logic ctr_taken(ctr_t c);
    return c[CTR_W-1];
  endfunction
endpackage

// File: rtl/ghp_index.sv
module ghp_index #(
  parameter int HIST_W  = 8,
  parameter int PC_BITS = 6,
  localparam int IDX_W  = HIST_W + PC_BITS
) (
  input  logic [HIST_W-1:0]  hist,
  input  logic [PC_BITS-1:0] pc_field,
  output logic [IDX_W-1:0]   idx
);
  assign idx = {hist, pc_field};
endmodule

// File: rtl/ghp_history.sv
module ghp_history #(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist
);
  always_ff @(posedge clk) begin
    if (rst)           hist <= '0;
    else if (shift_en) hist <= {hist[HIST_W-2:0], bit_in};
  end
endmodule

// File: rtl/ghp_counter_bank.sv
module ghp_counter_bank import ghp_pkg::*; #(
  parameter int IDX_W  = 14,
  parameter int SLOT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             up_en,
  input  logic [IDX_W-1:0] up_idx,
  input  logic             up_taken,
  output logic             busy
);
  localparam int ROW_W  = IDX_W - SLOT_W;
  localparam int SLOTS  = 1 << SLOT_W;
  localparam int WORD_W = SLOTS * CTR_W;
  localparam int ROWS   = 1 << ROW_W;
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

  logic [WORD_W-1:0] mem [ROWS];

  logic [WORD_W-1:0] init_word;
  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_init
      assign init_word[g*CTR_W +: CTR_W] = CTR_RESET;
    end
  endgenerate

  logic [ROW_W-1:0]  rd_row, up_row, sweep_row, wr_row;
  logic [SLOT_W-1:0] rd_slot, up_slot;
  logic [WORD_W-1:0] rd_word, up_word, wr_word;
  logic              wr_en;

  assign rd_row  = rd_idx[IDX_W-1:SLOT_W];
  assign rd_slot = rd_idx[SLOT_W-1:0];
  assign up_row  = up_idx[IDX_W-1:SLOT_W];
  assign up_slot = up_idx[SLOT_W-1:0];

  always_comb begin
    rd_word = mem[rd_row];
    rd_ctr  = rd_word[int'(rd_slot)*CTR_W +: CTR_W];
  end

  always_comb begin
    up_word = mem[up_row];
    up_word[int'(up_slot)*CTR_W +: CTR_W] =
      ctr_next(up_word[int'(up_slot)*CTR_W +: CTR_W], up_taken);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b1;
      sweep_row <= '0;
    end else if (busy) begin
      if (sweep_row == ROW_LAST) busy <= 1'b0;
      else                       sweep_row <= sweep_row + 1'b1;
    end
  end

  always_comb begin
    wr_en   = !rst && (busy || up_en);
    wr_row  = busy ? sweep_row : up_row;
    wr_word = busy ? init_word : up_word;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_row] <= wr_word;
  end
endmodule

// File: rtl/ghp_predictor.sv
module ghp_predictor import ghp_pkg::*; #(
  parameter int PC_W    = 32,
  parameter int HIST_W  = 8,
  parameter int PC_LSB  = 2,
  parameter int PC_BITS = 6,
  parameter int SLOT_W  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);
  localparam int IDX_W  = HIST_W + PC_BITS;
  localparam int PC_TOP = PC_LSB + PC_BITS - 1;

  logic [HIST_W-1:0] ghist;
  logic [IDX_W-1:0]  pred_idx, upd_idx;
  logic              init_busy, upd_fire;
  ctr_t              pred_ctr;

  logic unused_pc_bits;
  assign unused_pc_bits = ^{pred_pc, upd_pc};

  assign upd_fire = upd_valid && !init_busy;

  ghp_index #(.HIST_W(HIST_W), .PC_BITS(PC_BITS)) u_pred_index (
    .hist(ghist), .pc_field(pred_pc[PC_TOP:PC_LSB]), .idx(pred_idx));

  ghp_index #(.HIST_W(HIST_W), .PC_BITS(PC_BITS)) u_upd_index (
    .hist(ghist), .pc_field(upd_pc[PC_TOP:PC_LSB]), .idx(upd_idx));

  ghp_history #(.HIST_W(HIST_W)) u_history (
    .clk(clk), .rst(rst), .shift_en(upd_fire), .bit_in(upd_taken), .hist(ghist));

  ghp_counter_bank #(.IDX_W(IDX_W), .SLOT_W(SLOT_W)) u_bank (
    .clk(clk), .rst(rst),
    .rd_idx(pred_idx), .rd_ctr(pred_ctr),
    .up_en(upd_fire), .up_idx(upd_idx), .up_taken(upd_taken),
    .busy(init_busy));

  assign pred_taken = !init_busy && ctr_taken(pred_ctr);
endmodule

// File: rtl/ghp_predictor_chk.sv
module ghp_predictor_chk #(
  parameter int HIST_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic [HIST_W-1:0] hist,
  input logic              upd_valid,
  input logic              upd_taken,
  input logic              pred_taken
);
  // R5
  hist_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !busy) |=> hist == {$past(hist[HIST_W-2:0]), $past(upd_taken)});

  // R5
  hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(upd_valid && !busy) |=> $stable(hist));

  // R7
  sweep_hist_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> hist == '0);

  // R6
  sweep_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !pred_taken);

  // R7
  sweep_once_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !busy);

  // R4
  pred_known_chk: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(pred_taken));
endmodule

bind ghp_predictor ghp_predictor_chk #(.HIST_W(HIST_W)) u_chk (
  .clk(clk), .rst(rst), .busy(init_busy), .hist(ghist),
  .upd_valid(upd_valid), .upd_taken(upd_taken), .pred_taken(pred_taken));

// File: tb/ghp_predictor_test.sv
`timescale 1ns/100ps
module ghp_predictor_test;
  localparam int PC_W = 32;
  localparam int HW   = 8;
  localparam int NIDX = 1 << 14;
  localparam int ROWS = 2048;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PC_W-1:0] pred_pc = '0, upd_pc = '0;
  logic upd_valid = 1'b0, upd_taken = 1'b0;
  logic pred_taken;

  always #2.5 clk = ~clk;

  ghp_predictor uut (
    .clk(clk), .rst(rst), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference
  int m_ctr [NIDX];
  int m_hist = 0;
  bit m_busy = 1;
  int m_cnt = 0;
  bit m_valid = 0;

  function automatic int m_index(logic [PC_W-1:0] pc);
    return (m_hist << 6) | ((pc >> 2) & 63);
  endfunction

  function automatic bit m_pred(logic [PC_W-1:0] pc);
    if (m_busy) return 0;
    return m_ctr[m_index(pc)] >= 2;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NIDX; i++) m_ctr[i] = 1;
      m_hist = 0; m_busy = 1; m_cnt = 0; m_valid = 1;
    end else if (m_busy) begin
      m_cnt++;
      if (m_cnt == ROWS) m_busy = 0;
    end else if (upd_valid) begin
      int k;
      k = m_index(upd_pc);
      if (upd_taken) m_ctr[k] = (m_ctr[k] == 3) ? 3 : m_ctr[k] + 1;
      else           m_ctr[k] = (m_ctr[k] == 0) ? 0 : m_ctr[k] - 1;
      m_hist = ((m_hist << 1) | int'(upd_taken)) & 255;
    end
  end

  task automatic check(bit got, bit exp, string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  // R4: per-cycle comparison against the reference
  always @(negedge clk) begin
    #2;
    if (m_valid && !rst && !done) check(pred_taken, m_pred(pred_pc), "R4 per-cycle");
  end

  task automatic drive(logic [PC_W-1:0] ppc, bit uv, bit ut, logic [PC_W-1:0] upc);
    @(negedge clk);
    pred_pc = ppc; upd_valid = uv; upd_taken = ut; upd_pc = upc;
  endtask

  task automatic idle(logic [PC_W-1:0] ppc);
    drive(ppc, 0, 0, '0);
  endtask

  task automatic expect_now(bit exp, string tag);
    #1;
    check(pred_taken, exp, tag);
  endtask

  task automatic train(logic [PC_W-1:0] pc, bit t, int n);
    for (int i = 0; i < n; i++) drive('0, 1, t, pc);
  endtask

  task automatic do_reset();
    drive('0, 0, 0, '0);
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    do_reset();
    // R7: updates during the sweep are ignored, prediction not-taken
    for (int i = 0; i < 20; i++) begin
      drive(32'h40 + 32'(i*4), 1, 1, 32'h40);
      expect_now(0, "R7 sweep pred");
    end
    repeat (ROWS) idle('0);
    idle(32'h40);
    expect_now(0, "R7 sweep updates ignored");
    // R6: counters weakly not-taken after sweep
    idle(32'h0);    expect_now(0, "R6 reset counter");
    idle(32'hFC);   expect_now(0, "R6 reset counter");
    // R1/R5: history moves index
    train(32'h10, 1, 1);
    idle(32'h10);   expect_now(0, "R5 history shifted");
    train(32'h3C, 0, 8);
    idle(32'h10);   expect_now(1, "R1 trained counter");
    idle(32'h14);   expect_now(0, "R1 neighbour counter");
    idle(32'h110);  expect_now(1, "R9 high pc bits");
    idle(32'h13);   expect_now(1, "R9 low pc bits");
    // R2: saturation at 3 with history all ones
    train(32'h80, 1, 8);
    train(32'h24, 1, 5);
    drive(32'h24, 1, 0, 32'h24);
    expect_now(1, "R8 pre-update pred");
    train(32'h80, 1, 8);
    idle(32'h24);   expect_now(1, "R2 saturate high");
    // R8: same-cycle predict/update at one index
    drive(32'h58, 1, 1, 32'h58);
    expect_now(0, "R8 same cycle");
    idle(32'h58);   expect_now(1, "R8 after update");
    // R3: saturation at 0 with history zero
    train(32'h7C, 0, 8);
    train(32'h30, 0, 3);
    train(32'h30, 1, 1);
    train(32'h7C, 0, 8);
    idle(32'h30);   expect_now(0, "R3 saturate low");
    train(32'h30, 1, 1);
    train(32'h7C, 0, 8);
    idle(32'h30);   expect_now(1, "R4 threshold");
    // mixed stream, checked per cycle
    for (int i = 0; i < 400; i++)
      drive(32'h200 + 32'((i*7 % 5) * 4), 1, (i % 3) != 0, 32'h200 + 32'((i % 5) * 4));
    // R6: reset mid-run
    do_reset();
    idle(32'h10);   expect_now(0, "R7 pred in sweep");
    repeat (ROWS + 2) idle(32'h10);
    idle(32'h10);   expect_now(0, "R6 reset restores");
    idle(32'h24);   expect_now(0, "R6 reset restores");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule